// File: doc/BRIEF.md
# SCSI Controller Command Gate and Interrupt Unit

This block is the host-facing command front end of a SCSI protocol controller. The host writes 8-bit commands into a small register window. Each command is checked against the controller's connection state (free, initiator or target) and against a busy flag. An accepted command either finishes on the spot or sends a one-cycle start pulse to one of three external sequencers: selection, information transfer or bus reset. The sequencer later returns a done pulse that finishes the command.

The block holds two 8-bit interrupt request registers, each with an enable register, and drives an IRQ pin whose active level the host can choose. Request register 1 gathers command completion and the events the block sees on the SCSI bus: an information phase change (reported only once REQ is up), the target releasing BSY, and an external RST. Request register 0 collects event bits reported by the sequencers. A chip-reset command returns every register except the environment register to its reset value and flushes the FIFO.

Top module: `scsi_cmd_irq`

## Requirements
- R1: Command bits [7:6] give the category. 00 is accepted in any state, 01 only when neither initiator nor target, 10 only as target, and 11 only as initiator. A command that does not match the state is dropped: no start pulse, no output change and no completion bit.
- R2: While status bit 4 (command in progress) is 1, every command write other than chip reset (0x01) is dropped.
- R3: An accepted command that needs no sequencer leaves the busy flag at 0 and sets bit 0 (function complete) of request register 1. Chip reset (0x01) does not set it. The commands 0x00 and 0x80 are of this kind, and so are 0x03, which flushes the FIFO with a one-cycle fifo_flush pulse, and 0xC3/0xC4.
- R4: Accepted commands 0x41/0x42, 0xC0/0xC1 and 0x02 each give a one-cycle pulse on start_sel, start_xfr or start_brst respectively. The same accepting write sets the busy flag and places the command on active_cmd. A seq_done pulse while busy clears the flag and sets function complete.
- R5: A host read of request register 0 (address 1) or request register 1 (address 2) returns its value and clears it. An enable register read (addresses 3 and 4) has no side effect.
- R6: Status bit 7 is 1 whenever either request register is nonzero. The IRQ is active only when some request bit has its matching enable bit set. Enable register 0 is at address 3 and enable register 1 at address 4.
- R7: Bit 0 of the environment register (address 5) inverts irq_pin. A write to it takes effect on irq_pin from the cycle after the write.
- R8: As initiator, a change of {MSG, C/D, I/O} sets bit 1 of request register 1 only once REQ is high. If MSG is high at that point, bit 2 is set too.
- R9: As initiator, BSY falling sets bit 3 of request register 1 and clears the initiator flag (status bit 6).
- R10: A rising edge on bus_rst sets bit 4 of request register 1, clears the initiator and target flags (status bits 6 and 5) and atn_out, and pulses bus_release for one cycle. Status bit 0 follows bus_rst.
- R11: Chip reset clears the busy, initiator and target flags, both request registers, both enable registers and atn_out, and pulses fifo_flush. The environment register is kept.
- R12: An accepted 0x41/0x42 sets the initiator flag. A seq_fail pulse clears it. seq_irq0_set ORs its bits into request register 0. 0xC3 drives atn_out high and 0xC4 drives it low. A seq_tgt pulse while not initiator sets the target flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, also clears the environment register |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (clears request registers) |
| reg_addr | input | AW | Register address: 0 command/status, 1-2 requests, 3-4 enables, 5 environment |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| bus_bsy | input | 1 | Bus BSY monitor |
| bus_msg | input | 1 | Bus MSG monitor |
| bus_cd | input | 1 | Bus C/D monitor |
| bus_io | input | 1 | Bus I/O monitor |
| bus_req | input | 1 | Bus REQ monitor |
| bus_rst | input | 1 | Bus RST monitor |
| seq_done | input | 1 | Sequencer finished pulse |
| seq_fail | input | 1 | Sequencer lost the connection (clears initiator) |
| seq_tgt | input | 1 | Controller was selected as target |
| seq_irq0_set | input | 8 | Bits to set in request register 0 |
| start_sel | output | 1 | Start pulse to the selection sequencer |
| start_xfr | output | 1 | Start pulse to the transfer sequencer |
| start_brst | output | 1 | Start pulse to the bus-reset sequencer |
| active_cmd | output | 8 | Command held while busy |
| fifo_flush | output | 1 | FIFO flush and DRQ drop pulse |
| bus_release | output | 1 | Release-all-bus-drive pulse |
| atn_out | output | 1 | ATN drive level |
| irq_pin | output | 1 | Interrupt pin after polarity |

## Verification
The hardest case to reach is a phase change that is held back. To get there, the controller must first be an initiator, which takes an accepted selection command and its done pulse. BSY must then be high, the phase lines must change while REQ stays low for several cycles, and only after that may REQ rise. The bench walks through this sequence and reads request register 1 both before and after REQ rises, once for a C/D change and once for a MSG change. It then drops BSY to confirm that a disconnect ends the initiator role.

// File: rtl/scsi_cmd_irq.sv
module scsi_cmd_irq #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          bus_bsy,
  input  logic          bus_msg,
  input  logic          bus_cd,
  input  logic          bus_io,
  input  logic          bus_req,
  input  logic          bus_rst,
  input  logic          seq_done,
  input  logic          seq_fail,
  input  logic          seq_tgt,
  input  logic [7:0]    seq_irq0_set,
  output logic          start_sel,
  output logic          start_xfr,
  output logic          start_brst,
  output logic [7:0]    active_cmd,
  output logic          fifo_flush,
  output logic          bus_release,
  output logic          atn_out,
  output logic          irq_pin
);
  localparam logic [AW-1:0] A_CMD = AW'(0);
  localparam logic [AW-1:0] A_IR0 = AW'(1);
  localparam logic [AW-1:0] A_IR1 = AW'(2);
  localparam logic [AW-1:0] A_EN0 = AW'(3);
  localparam logic [AW-1:0] A_EN1 = AW'(4);
  localparam logic [AW-1:0] A_ENV = AW'(5);

  localparam logic [7:0] C_CHIPRST = 8'h01;
  localparam logic [7:0] C_BUSRST  = 8'h02;
  localparam logic [7:0] C_FLUSH   = 8'h03;
  localparam logic [7:0] C_SEL     = 8'h41;
  localparam logic [7:0] C_SELATN  = 8'h42;
  localparam logic [7:0] C_XFR     = 8'h C0;
  localparam logic [7:0] C_PAD     = 8'hC1;
  localparam logic [7:0] C_ATNON   = 8'hC3;
  localparam logic [7:0] C_ATNOFF  = 8'hC4;

  logic [7:0] req0_q, req1_q, en0_q, en1_q, env_q, cmd_q;
  logic       init_q, targ_q, cip_q, rst_q, bsy_q;
  logic [2:0] ph_ref_q;

  logic cmd_we, state_ok, is_chiprst, accept, go_sel, go_xfr, go_brst, needs_seq, immediate;
  logic rst_rise, disc, ph_diff, ph_chg, fnc_set, irq_act;
  logic [2:0] phase;
  logic [7:0] set1, clr0, clr1;

  assign cmd_we     = reg_wr && (reg_addr == A_CMD);
  assign is_chiprst = (reg_wdata == C_CHIPRST);

  always_comb begin
    case (reg_wdata[7:6])
      2'b00:   state_ok = 1'b1;
      2'b01:   state_ok = !init_q && !targ_q;
      2'b10:   state_ok = targ_q && !init_q;
      default: state_ok = init_q && !targ_q;
    endcase
  end

  assign accept    = cmd_we && state_ok && (!cip_q || is_chiprst);
  assign go_sel    = accept && (reg_wdata == C_SEL || reg_wdata == C_SELATN);
  assign go_xfr    = accept && (reg_wdata == C_XFR || reg_wdata == C_PAD);
  assign go_brst   = accept && (reg_wdata == C_BUSRST);
  assign needs_seq = go_sel || go_xfr || go_brst;
  assign immediate = accept && !needs_seq && !is_chiprst;
  wire   chiprst   = accept && is_chiprst;

  assign phase    = {bus_msg, bus_cd, bus_io};
  assign rst_rise = bus_rst && !rst_q;
  assign disc     = init_q && bsy_q && !bus_bsy && !rst_rise;
  assign ph_diff  = init_q && !disc && !rst_rise && (phase != ph_ref_q);
  assign ph_chg   = ph_diff && bus_req;
  assign fnc_set  = immediate || (seq_done && cip_q);

  assign set1 = {3'b000, rst_rise, disc, ph_chg && bus_msg, ph_chg, fnc_set};
  assign clr0 = (reg_rd && reg_addr == A_IR0) ? 8'hFF : 8'h00;
  assign clr1 = (reg_rd && reg_addr == A_IR1) ? 8'hFF : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req0_q <= '0; req1_q <= '0; en0_q <= '0; en1_q <= '0; env_q <= '0; cmd_q <= '0;
      init_q <= 1'b0; targ_q <= 1'b0; cip_q <= 1'b0; atn_out <= 1'b0;
      rst_q <= 1'b0; bsy_q <= 1'b0; ph_ref_q <= '0;
      start_sel <= 1'b0; start_xfr <= 1'b0; start_brst <= 1'b0;
      fifo_flush <= 1'b0; bus_release <= 1'b0;
    end else begin
      rst_q       <= bus_rst;
      bsy_q       <= bus_bsy;
      start_sel   <= go_sel;
      start_xfr   <= go_xfr;
      start_brst  <= go_brst;
      fifo_flush  <= chiprst || (accept && reg_wdata == C_FLUSH);
      bus_release <= rst_rise;
      if (!(ph_diff && !bus_req)) ph_ref_q <= phase;

      if (reg_wr && reg_addr == A_ENV) env_q <= reg_wdata;

      if (chiprst) begin
        req0_q <= '0; req1_q <= '0; en0_q <= '0; en1_q <= '0; cmd_q <= '0;
        init_q <= 1'b0; targ_q <= 1'b0; cip_q <= 1'b0; atn_out <= 1'b0;
      end else begin
        req0_q <= (req0_q & ~clr0) | seq_irq0_set;
        req1_q <= (req1_q & ~clr1) | set1;
        if (reg_wr && reg_addr == A_EN0) en0_q <= reg_wdata;
        if (reg_wr && reg_addr == A_EN1) en1_q <= reg_wdata;

        if (needs_seq) begin
          cip_q <= 1'b1;
          cmd_q <= reg_wdata;
        end else if (seq_done) begin
          cip_q <= 1'b0;
          cmd_q <= '0;
        end

        if (rst_rise || disc || seq_fail) init_q <= 1'b0;
        else if (go_sel)                  init_q <= 1'b1;

        if (rst_rise)                   targ_q <= 1'b0;
        else if (seq_tgt && !init_q)    targ_q <= 1'b1;

        if (rst_rise)                                atn_out <= 1'b0;
        else if (accept && reg_wdata == C_ATNON)     atn_out <= 1'b1;
        else if (accept && reg_wdata == C_ATNOFF)    atn_out <= 1'b0;
      end
    end
  end

  assign active_cmd = cmd_q;
  assign irq_act    = |(req0_q & en0_q) || |(req1_q & en1_q);
  assign irq_pin    = irq_act ^ env_q[0];

  always_comb begin
    case (reg_addr)
      A_CMD:   reg_rdata = {(|req0_q) || (|req1_q), init_q, targ_q, cip_q, 3'b000, bus_rst};
      A_IR0:   reg_rdata = req0_q;
      A_IR1:   reg_rdata = req1_q;
      A_EN0:   reg_rdata = en0_q;
      A_EN1:   reg_rdata = en1_q;
      A_ENV:   reg_rdata = env_q;
      default: reg_rdata = '0;
    endcase
  end

  a_r2_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cip_q && cmd_we && reg_wdata != C_CHIPRST) |=> !(start_sel || start_xfr || start_brst || fifo_flush));

  a_r4_one_start: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_sel, start_xfr, start_brst}));

  a_r4_done_finishes: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && cip_q && !cmd_we) |=> (!cip_q && req1_q[0]));

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_IR0 && seq_irq0_set == 8'h00) |=> (req0_q == 8'h00));

  a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (req0_q == 8'h00 && req1_q == 8'h00) |-> (irq_pin == env_q[0]));

  a_r10_bus_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rst) |=> (!init_q && !targ_q && bus_release));
endmodule

// File: tb/test_scsi_cmd_irq.sv
module test_scsi_cmd_irq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic bus_bsy = 0, bus_msg = 0, bus_cd = 0, bus_io = 0, bus_req = 0, bus_rst = 0;
  logic seq_done = 0, seq_fail = 0, seq_tgt = 0;
  logic [7:0] seq_irq0_set = '0;
  logic start_sel, start_xfr, start_brst, fifo_flush, bus_release, atn_out, irq_pin;
  logic [7:0] active_cmd;
  int errs = 0, n = 0;
  bit done = 0;

  always #2 clk = ~clk;

  scsi_cmd_irq i_scsi_cmd_irq (.*);

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int k = 1);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic rdchk(string tag, logic [2:0] a, logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic pulse_done();
    @(negedge clk); seq_done = 1;
    @(negedge clk); seq_done = 0;
  endtask

  task automatic become_init();
    wr(0, 8'h41);
    pulse_done();
    rdchk("R4 select done", 2, 8'h01);
  endtask

  task automatic t_reset_state();
    rdchk("R11 reset status", 0, 8'h00);
    check("R7 reset irq_pin", irq_pin, 0);
    check("R12 reset atn", atn_out, 0);
  endtask

  task automatic t_category();
    wr(0, 8'hC3);
    check("R1 initiator cmd dropped when free", atn_out, 0);
    rdchk("R1 no completion", 2, 8'h00);
    wr(0, 8'h80);
    rdchk("R1 target cmd dropped when free", 2, 8'h00);
    @(negedge clk); seq_tgt = 1; @(negedge clk); seq_tgt = 0;
    rdchk("R12 target flag", 0, 8'h20);
    wr(0, 8'h80);
    rdchk("R3 target no-op completes", 2, 8'h01);
    wr(0, 8'h41);
    check("R1 select dropped as target", start_sel, 0);
    rdchk("R1 state unchanged", 0, 8'h20);
    wr(0, 8'h01);
  endtask

  task automatic t_immediate();
    wr(0, 8'h00);
    rdchk("R3 nop completes", 2, 8'h01);
    wr(0, 8'h03);
    check("R3 flush pulse", fifo_flush, 1);
    tick();
    check("R3 flush one cycle", fifo_flush, 0);
    rdchk("R3 flush completes", 2, 8'h01);
    rdchk("R5 cleared after read", 2, 8'h00);
  endtask

  task automatic t_select();
    wr(0, 8'h42);
    check("R4 start_sel", start_sel, 1);
    check("R4 active_cmd", active_cmd, 8'h42);
    tick();
    check("R4 start_sel one cycle", start_sel, 0);
    rdchk("R4 busy and initiator", 0, 8'h50);
    wr(0, 8'h03);
    check("R2 flush dropped while busy", fifo_flush, 0);
    pulse_done();
    rdchk("R4 done status", 0, 8'hC0);
    rdchk("R4 done sets complete", 2, 8'h01);
    wr(0, 8'hC0);
    check("R4 start_xfr", start_xfr, 1);
    wr(0, 8'hC3);
    check("R2 atn dropped while busy", atn_out, 0);
    wr(0, 8'h01);
    check("R2 chip reset accepted while busy", fifo_flush, 1);
    rdchk("R11 busy and initiator cleared", 0, 8'h00);
    wr(0, 8'h02);
    check("R4 start_brst", start_brst, 1);
    pulse_done();
    rdchk("R4 bus reset done", 2, 8'h01);
  endtask

  task automatic t_atn_fail();
    become_init();
    wr(0, 8'hC3);
    check("R12 atn on", atn_out, 1);
    wr(0, 8'hC4);
    check("R12 atn off", atn_out, 0);
    rdchk("R3 atn cmds complete", 2, 8'h01);
    @(negedge clk); seq_fail = 1; seq_irq0_set = 8'h04;
    @(negedge clk); seq_fail = 0; seq_irq0_set = 8'h00;
    rdchk("R12 fail clears initiator", 0, 8'h80);
    rdchk("R12 req0 bits", 1, 8'h04);
    rdchk("R5 req0 cleared", 1, 8'h00);
  endtask

  task automatic t_irq();
    wr(4, 8'h01);
    wr(0, 8'h00);
    check("R6 enabled request asserts irq", irq_pin, 1);
    wr(5, 8'h01);
    check("R7 polarity inverts", irq_pin, 0);
    wr(4, 8'h00);
    check("R6 masked request", irq_pin, 1);
    rdchk("R6 summary with mask", 0, 8'h80);
    rdchk("R5 enable read no clear", 4, 8'h00);
    rdchk("R5 req1 read", 2, 8'h01);
    check("R7 idle inverted", irq_pin, 1);
    wr(5, 8'h00);
    check("R7 idle normal", irq_pin, 0);
    wr(3, 8'h10);
    @(negedge clk); seq_irq0_set = 8'h10; @(negedge clk); seq_irq0_set = 8'h00;
    check("R6 req0 enabled", irq_pin, 1);
    rdchk("R5 en0 kept", 3, 8'h10);
    rdchk("R5 req0 read", 1, 8'h10);
    check("R6 irq drops after read", irq_pin, 0);
    wr(3, 8'h00);
  endtask

  task automatic t_phase();
    become_init();
    bus_bsy = 1; tick(2);
    bus_cd = 1; tick(3);
    rdchk("R8 held without REQ", 2, 8'h00);
    bus_req = 1; tick(2);
    rdchk("R8 phase change on REQ", 2, 8'h02);
    bus_req = 0; bus_msg = 1; tick(3);
    rdchk("R8 msg held without REQ", 2, 8'h00);
    bus_req = 1; tick(2);
    rdchk("R8 message received", 2, 8'h06);
    bus_req = 0; bus_bsy = 0; tick(2);
    rdchk("R9 disconnect", 2, 8'h08);
    rdchk("R9 initiator cleared", 0, 8'h00);
    bus_msg = 0; bus_cd = 0; tick(2);
    rdchk("R8 no event when free", 2, 8'h00);
  endtask

  task automatic t_busrst();
    become_init();
    wr(0, 8'hC3);
    rdchk("R3 atn complete", 2, 8'h01);
    @(negedge clk); bus_rst = 1;
    @(negedge clk);
    check("R10 bus_release pulse", bus_release, 1);
    tick();
    check("R10 bus_release one cycle", bus_release, 0);
    check("R10 atn released", atn_out, 0);
    rdchk("R10 status", 0, 8'h81);
    rdchk("R10 reset interrupt", 2, 8'h10);
    bus_rst = 0; tick();
  endtask

  task automatic t_chipreset();
    wr(3, 8'h33); wr(4, 8'h44); wr(5, 8'h01);
    become_init();
    wr(0, 8'h01);
    check("R11 flush pulse", fifo_flush, 1);
    rdchk("R11 en0 cleared", 3, 8'h00);
    rdchk("R11 en1 cleared", 4, 8'h00);
    rdchk("R11 env kept", 5, 8'h01);
    rdchk("R11 status cleared", 0, 8'h00);
    rdchk("R3 chip reset no completion", 2, 8'h00);
    wr(5, 8'h00);
  endtask

  initial begin
    tick(3); rst_n = 1; tick(2);
    t_reset_state();
    t_category();
    t_immediate();
    t_select();
    t_atn_fail();
    t_irq();
    t_phase();
    t_busrst();
    t_chipreset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, n);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; n++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, n);
      $finish;
    end
  end
endmodule